// File: doc/BRIEF.md
# Phase-Locked Processor Clock Divider with Peripheral Wait States

This block takes a fast master clock (16 MHz in the default build) and runs it through a cascade of divide-by-two stages. One stage output drives the processor clock. A two-bit select code, written by software, picks which stage that is. The slowest stage always drives a fixed 1 MHz clock for a slow peripheral.

The stages count down, so every stage output rises on the same master edge when the chain wraps. The processor clock and the peripheral clock therefore always rise together. A new select code is held as pending and takes over only at that common rising edge, and only when no peripheral access is in progress. This prevents any shortened clock pulse.

When the peripheral chip select is seen at the start of a processor cycle, a small state machine stretches the access. It pulls the ready line low for (processor MHz − 1) processor cycles, so that the access always lasts exactly one peripheral clock period. The peripheral bus buffer is enabled for the whole access and at no other time, whatever the clocks are doing.

The state machine has three states. ST_IDLE is the idle state. ST_WAIT is the state in which wait states are inserted. ST_LAST is the final, ready cycle of an access. Its transitions are:

- ST_IDLE→ST_WAIT: chip select seen at a processor-cycle start while the ratio is above 1.
- ST_IDLE→ST_LAST: chip select seen at 1 MHz.
- ST_WAIT→ST_WAIT: a cycle start while the wait count is above 1. The count drops by one.
- ST_WAIT→ST_LAST: a cycle start with a wait count of 1.
- ST_LAST→ST_IDLE: the next cycle start.

In ST_IDLE and ST_LAST the state is held until a processor-cycle start arrives.

Top module: `clkdiv_waitgen`

## Requirements
- R1: While reset is low, cpu_phi2=0, per_phi2=0, rdy=1 and buf_oe=0. After reset the select code is 3 (1 MHz).
- R2: Select code s (sel_wdata, 2 bits) gives cpu_phi2 a period of 2^(s+1) master cycles with exactly half of them high. The codes map as 0=8 MHz, 1=4 MHz, 2=2 MHz, 3=1 MHz.
- R3: per_phi2 has a period of 16 master cycles with 8 high. Every rising edge of per_phi2 falls on a master edge where cpu_phi2 also rises.
- R4: A written select code takes effect only at a rising edge of per_phi2 when no access is active. cpu_phi2 high and low runs always have the full length of either the old rate or the new rate.
- R5: per_cs is sampled at the master edge where cpu_phi2 rises. From that edge rdy is low for 2^(3−s)−1 processor cycles, which is 16−2^(s+1) master cycles.
- R6: At select code 3 an access keeps rdy high throughout.
- R7: buf_oe is high for exactly the access, which is 16 master cycles starting at the sampling edge. It is low whenever no access is active, independent of cpu_phi2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_master | input | 1 | Master clock (16 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Write strobe for the rate select |
| sel_wdata | input | 2 | Rate select code (0=8, 1=4, 2=2, 3=1 MHz) |
| per_cs | input | 1 | Peripheral chip select from the address decoder |
| cpu_phi2 | output | 1 | Processor clock |
| per_phi2 | output | 1 | Fixed 1 MHz peripheral clock, rising edges aligned with cpu_phi2 |
| rdy | output | 1 | Processor ready, low during wait states |
| buf_oe | output | 1 | Peripheral bus buffer enable |

## Verification
The divider is run at each of the four select codes. Measuring the period and the high time separates the rates and confirms the 50% duty. A peripheral access is issued at each rate. The length of the rdy-low window separates the 7, 3, 1 and 0 wait-state cases, while the buffer window must stay at 16 cycles in all of them. Rate switches in both directions, from fastest to slowest and back, expose any runt pulse or a switch point that is not on a 1 MHz rising edge. A long idle stretch with a toggling clock shows that the buffer stays off when no access is active.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_LAST = 2'd2
    } acc_state_e;
endpackage

// File: rtl/div_chain.sv
module div_chain #(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES-1:0] cnt_q,
    output logic [STAGES-1:0] cnt_d
);
    // Down-counting toggle stages: stage k flips when all lower stages are zero,
    // so every stage rises together when the chain wraps.
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign cnt_d[k] = ~cnt_q[k];
        end else begin : g_next
            assign cnt_d[k] = cnt_q[k] ^ (cnt_q[k-1:0] == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tap_select.sv
module tap_select #(
    parameter int STAGES = 4,
    localparam int SEL_W = $clog2(STAGES),
    localparam int PER_TAP = STAGES - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_we,
    input  logic [SEL_W-1:0]  sel_wdata,
    input  logic              hold,
    input  logic [STAGES-1:0] cnt_q,
    input  logic [STAGES-1:0] cnt_d,
    output logic [SEL_W-1:0]  sel_act,
    output logic [SEL_W-1:0]  sel_nxt,
    output logic              tick,
    output logic              cpu_phi2,
    output logic              per_phi2
);
    logic [SEL_W-1:0]  sel_pend;
    logic [STAGES-1:0] mask;
    logic              wrap;

    assign wrap = (cnt_q == '0);

    always_comb begin
        sel_nxt = (wrap && !hold) ? sel_pend : sel_act;
        mask    = '0;
        for (int k = 0; k < STAGES; k++) begin
            if (k <= int'(sel_act)) mask[k] = 1'b1;
        end
    end

    // Processor cycle begins on the next edge when all selected stages are zero now.
    assign tick = ((cnt_q & mask) == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_pend <= SEL_W'(PER_TAP);
            sel_act  <= SEL_W'(PER_TAP);
            cpu_phi2 <= 1'b0;
            per_phi2 <= 1'b0;
        end else begin
            if (sel_we) sel_pend <= sel_wdata;
            sel_act  <= sel_nxt;
            cpu_phi2 <= cnt_d[sel_nxt];
            per_phi2 <= cnt_d[PER_TAP];
        end
    end
endmodule

// File: rtl/wait_fsm.sv
module wait_fsm
    import clkdiv_pkg::*;
#(
    parameter int STAGES = 4,
    localparam int SEL_W = $clog2(STAGES),
    localparam int PER_TAP = STAGES - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             per_cs,
    input  logic [SEL_W-1:0] sel_nxt,
    output acc_state_e       state,
    output logic             rdy,
    output logic             buf_oe
);
    acc_state_e        state_d;
    logic [STAGES-1:0] wcnt_q, wcnt_d, waits;

    always_comb begin
        waits = STAGES'((1 << (PER_TAP - int'(sel_nxt))) - 1);
    end

    always_comb begin
        state_d = state;
        wcnt_d  = wcnt_q;
        unique case (state)
            ST_IDLE: if (tick && per_cs) begin
                wcnt_d  = waits;
                state_d = (waits == '0) ? ST_LAST : ST_WAIT;
            end
            ST_WAIT: if (tick) begin
                wcnt_d  = wcnt_q - STAGES'(1);
                if (wcnt_q == STAGES'(1)) state_d = ST_LAST;
            end
            ST_LAST: if (tick) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            wcnt_q <= '0;
        end else begin
            state  <= state_d;
            wcnt_q <= wcnt_d;
        end
    end

    always_comb begin
        rdy    = (state != ST_WAIT);
        buf_oe = (state != ST_IDLE);
    end
endmodule

// File: rtl/clkdiv_waitgen.sv
module clkdiv_waitgen
    import clkdiv_pkg::*;
#(
    parameter int DIV_STAGES = 4,
    localparam int SEL_W = $clog2(DIV_STAGES)
) (
    input  logic             clk_master,
    input  logic             rst_n,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             per_cs,
    output logic             cpu_phi2,
    output logic             per_phi2,
    output logic             rdy,
    output logic             buf_oe
);
    logic [DIV_STAGES-1:0] cnt_q, cnt_d;
    logic [SEL_W-1:0]      sel_act, sel_nxt;
    logic                  tick;
    acc_state_e            state;

    div_chain #(.STAGES(DIV_STAGES)) u_chain (
        .clk   (clk_master),
        .rst_n (rst_n),
        .cnt_q (cnt_q),
        .cnt_d (cnt_d)
    );

    tap_select #(.STAGES(DIV_STAGES)) u_taps (
        .clk       (clk_master),
        .rst_n     (rst_n),
        .sel_we    (sel_we),
        .sel_wdata (sel_wdata),
        .hold      (state != ST_IDLE),
        .cnt_q     (cnt_q),
        .cnt_d     (cnt_d),
        .sel_act   (sel_act),
        .sel_nxt   (sel_nxt),
        .tick      (tick),
        .cpu_phi2  (cpu_phi2),
        .per_phi2  (per_phi2)
    );

    wait_fsm #(.STAGES(DIV_STAGES)) u_fsm (
        .clk     (clk_master),
        .rst_n   (rst_n),
        .tick    (tick),
        .per_cs  (per_cs),
        .sel_nxt (sel_nxt),
        .state   (state),
        .rdy     (rdy),
        .buf_oe  (buf_oe)
    );
endmodule

// File: rtl/clkdiv_waitgen_chk.sv
module clkdiv_waitgen_chk #(
    parameter int SEL_W = 2,
    parameter int PER_TAP = 3
) (
    input logic             clk_master,
    input logic             rst_n,
    input logic             cpu_phi2,
    input logic             per_phi2,
    input logic             rdy,
    input logic             buf_oe,
    input logic [SEL_W-1:0] sel_act
);
    p_aligned_rise_r3: assert property (@(posedge clk_master) disable iff (!rst_n)
        $rose(per_phi2) |-> $rose(cpu_phi2));

    p_sel_at_wrap_r4: assert property (@(posedge clk_master) disable iff (!rst_n)
        !$stable(sel_act) |-> $rose(per_phi2));

    p_wait_in_access_r5: assert property (@(posedge clk_master) disable iff (!rst_n)
        !rdy |-> buf_oe);

    p_no_wait_slow_r6: assert property (@(posedge clk_master) disable iff (!rst_n)
        (sel_act == SEL_W'(PER_TAP)) && $stable(sel_act) |-> rdy);

    p_oe_ends_ready_r7: assert property (@(posedge clk_master) disable iff (!rst_n)
        $fell(buf_oe) |-> rdy && $past(rdy));

    p_oe_starts_on_rise_r7: assert property (@(posedge clk_master) disable iff (!rst_n)
        $rose(buf_oe) |-> $rose(cpu_phi2));
endmodule

bind clkdiv_waitgen clkdiv_waitgen_chk #(.SEL_W(SEL_W), .PER_TAP(DIV_STAGES - 1)) u_chk (
    .clk_master (clk_master),
    .rst_n      (rst_n),
    .cpu_phi2   (cpu_phi2),
    .per_phi2   (per_phi2),
    .rdy        (rdy),
    .buf_oe     (buf_oe),
    .sel_act    (sel_act)
);

// File: tb/test_clkdiv_waitgen.sv
module test_clkdiv_waitgen;
    localparam int CLK_PERIOD = 10;

    logic       clk_master = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_we = 1'b0;
    logic [1:0] sel_wdata = 2'd0;
    logic       per_cs = 1'b0;
    logic       cpu_phi2, per_phi2, rdy, buf_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int    rdy_low;
        int    oe_len;
        int    first_rdy;
        string tag;
    } exp_item_t;
    exp_item_t exp_q[$];

    clkdiv_waitgen i_clkdiv_waitgen (
        .clk_master (clk_master),
        .rst_n      (rst_n),
        .sel_we     (sel_we),
        .sel_wdata  (sel_wdata),
        .per_cs     (per_cs),
        .cpu_phi2   (cpu_phi2),
        .per_phi2   (per_phi2),
        .rdy        (rdy),
        .buf_oe     (buf_oe)
    );

    always #(CLK_PERIOD/2) clk_master = ~clk_master;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic set_sel(input int s);
        @(negedge clk_master);
        sel_we = 1'b1;
        sel_wdata = 2'(s);
        @(negedge clk_master);
        sel_we = 1'b0;
        repeat (40) @(negedge clk_master);
    endtask

    // R2: period and high time of cpu_phi2 at the current code
    task automatic measure(input int s);
        int per, hi;
        logic prev;
        per = 0; hi = 0;
        prev = cpu_phi2;
        forever begin
            @(negedge clk_master);
            if (cpu_phi2 && !prev) break;
            prev = cpu_phi2;
        end
        do begin
            per++;
            if (cpu_phi2) hi++;
            prev = cpu_phi2;
            @(negedge clk_master);
        end while (!(cpu_phi2 && !prev));
        chk(per == (2 << s), $sformatf("R2 period code %0d", s), per, 2 << s);
        chk(hi == (1 << s), $sformatf("R2 high time code %0d", s), hi, 1 << s);
    endtask

    // R3: per_phi2 shape and alignment with cpu_phi2
    task automatic check_align();
        int bad, per_hi;
        logic pc, pp;
        bad = 0; per_hi = 0;
        pc = cpu_phi2; pp = per_phi2;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk_master);
            if (per_phi2) per_hi++;
            if (per_phi2 && !pp && !(cpu_phi2 && !pc)) bad++;
            pc = cpu_phi2; pp = per_phi2;
        end
        chk(bad == 0, "R3 per_phi2 rise without cpu_phi2 rise", bad, 0);
        chk(per_hi == 16, "R3 per_phi2 high count over 32 cycles", per_hi, 16);
    endtask

    // R4: switch rate, no runt, new rate starts on a per_phi2 rise
    task automatic switch_runs(input int from_s, input int to_s);
        int runlen, bad, trans, first_new_ok;
        bit seen_new, start_al;
        logic pc, pp;
        runlen = 0; bad = 0; trans = 0; first_new_ok = -1;
        seen_new = 1'b0; start_al = 1'b0;
        @(negedge clk_master);
        sel_we = 1'b1;
        sel_wdata = 2'(to_s);
        pc = cpu_phi2; pp = per_phi2;
        for (int i = 0; i < 72; i++) begin
            @(negedge clk_master);
            sel_we = 1'b0;
            if (cpu_phi2 != pc) begin
                if (trans > 0) begin
                    if (runlen != (1 << from_s) && runlen != (1 << to_s)) bad++;
                    if (!seen_new && runlen == (1 << to_s)) begin
                        seen_new = 1'b1;
                        first_new_ok = start_al ? 1 : 0;
                    end
                end
                trans++;
                runlen = 1;
                start_al = per_phi2 && !pp;
            end else begin
                runlen++;
            end
            pc = cpu_phi2; pp = per_phi2;
        end
        chk(bad == 0, $sformatf("R4 runt during %0d->%0d", from_s, to_s), bad, 0);
        chk(first_new_ok == 1, $sformatf("R4 switch point %0d->%0d", from_s, to_s), first_new_ok, 1);
        repeat (20) @(negedge clk_master);
    endtask

    // Driver: push expected access shape, then issue the access (R5, R6, R7)
    task automatic access(input int s);
        exp_item_t it;
        int w;
        w = (1 << (3 - s)) - 1;
        it.rdy_low = 16 - (2 << s);
        it.oe_len = 16;
        it.first_rdy = (w == 0) ? 1 : 0;
        it.tag = (s == 3) ? "R6" : "R5";
        exp_q.push_back(it);
        @(negedge clk_master);
        per_cs = 1'b1;
        do @(negedge clk_master); while (!buf_oe);
        per_cs = 1'b0;
        do @(negedge clk_master); while (buf_oe);
        repeat (5) @(negedge clk_master);
    endtask

    // Monitor: measure each access window and compare with the queue
    initial begin
        logic prev_oe, prev_cpu;
        int oe_len, rdy_low, first_rdy, cpu_rose;
        exp_item_t e;
        prev_oe = 1'b0; prev_cpu = 1'b0;
        oe_len = 0; rdy_low = 0; first_rdy = 0; cpu_rose = 0;
        forever begin
            @(negedge clk_master);
            if (rst_n) begin
                if (buf_oe && !prev_oe) begin
                    oe_len = 0; rdy_low = 0;
                    first_rdy = rdy ? 1 : 0;
                    cpu_rose = (cpu_phi2 && !prev_cpu) ? 1 : 0;
                end
                if (buf_oe) begin
                    oe_len++;
                    if (!rdy) rdy_low++;
                end
                if (!buf_oe && prev_oe) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R7 unexpected buffer window", oe_len, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(rdy_low == e.rdy_low, {e.tag, " rdy low cycles"}, rdy_low, e.rdy_low);
                        chk(first_rdy == e.first_rdy, {e.tag, " rdy in sampling cycle"}, first_rdy, e.first_rdy);
                        chk(oe_len == e.oe_len, "R7 buffer window length", oe_len, e.oe_len);
                        chk(cpu_rose == 1, "R5 access starts on cpu_phi2 rise", cpu_rose, 1);
                    end
                end
            end
            prev_oe = buf_oe; prev_cpu = cpu_phi2;
        end
    end

    initial begin
        repeat (200000) @(posedge clk_master);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int idle_bad;
        repeat (3) @(negedge clk_master);
        // R1 reset values
        chk(cpu_phi2 == 1'b0, "R1 cpu_phi2 in reset", cpu_phi2, 0);
        chk(per_phi2 == 1'b0, "R1 per_phi2 in reset", per_phi2, 0);
        chk(rdy == 1'b1, "R1 rdy in reset", rdy, 1);
        chk(buf_oe == 1'b0, "R1 buf_oe in reset", buf_oe, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk_master);
        measure(3); // R1 default code is 3
        check_align();

        for (int s = 0; s < 4; s++) begin
            set_sel(s);
            measure(s);
            check_align();
            access(s);
        end

        // R7 buffer stays off while idle with clocks running
        idle_bad = 0;
        for (int i = 0; i < 48; i++) begin
            @(negedge clk_master);
            if (buf_oe || !rdy) idle_bad++;
        end
        chk(idle_bad == 0, "R7 buffer or wait while idle", idle_bad, 0);

        set_sel(0);
        switch_runs(0, 3);
        switch_runs(3, 0);
        set_sel(1);
        access(1);
        access(1);

        repeat (10) @(negedge clk_master);
        chk(exp_q.size() == 0, "R5 pending expected accesses", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule